// File: doc/BRIEF.md
# Channel-Tagged Conversion Word Buffer

This block is a first-in first-out store that sits between the result latch of an analog-to-digital converter and an 8-bit host bus. Each conversion word carries a 12-bit sample in its upper bits and a 4-bit channel tag in its lower bits. While the buffer is enabled it accepts these words as they arrive, and the host reads them back one byte at a time.

The buffer raises an interrupt once it becomes half full. The host can then drain a fixed burst of half the depth in words for each interrupt. Status reports empty, at-least-half-full and a sticky overflow flag. The host bus offers three control actions: an enable byte, an interrupt acknowledge (any write), and a flush (any write) that shares its address with the status read. The expected shutdown order is acknowledge, then flush, then disable.

Top module: `tagfifo_top`

## Requirements
- R1: The buffer holds up to 1024 words of 16 bits and returns them in arrival order.
- R2: A read of address 2 returns status with bit 0 = empty, bit 1 = holding 512 or more words, bit 2 = overflow, and bits 7:3 = 0.
- R3: A read of address 3 returns bits 7:0 of the oldest word and a read of address 4 returns bits 15:8. The word is stored unchanged, with the sample in bits 15:4 and the channel tag in bits 3:0.
- R4: A write to address 0 stores the control byte, and a read of address 0 returns it. A word on conv_valid is stored only while bit 0 of that byte is 1; otherwise it is dropped and the status does not change.
- R5: Reading address 4 removes the oldest word. Reading address 3 removes nothing. Reading address 4 while empty changes no state.
- R6: A word that arrives while 1024 words are held, with no removal in the same cycle, is dropped and sets the overflow bit. The bit then stays set. If a removal happens in that same cycle, the word is accepted.
- R7: Any write to address 2 empties the buffer and clears overflow. A word arriving in the same cycle is dropped. The flush changes neither the control byte nor the interrupt.
- R8: irq rises at the clock edge after status bit 1 goes from 0 to 1. It stays high until a write to address 1. If a new crossing coincides with that write, irq stays high.
- R9: After reset the buffer is empty, overflow is 0, the control byte is 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| conv_valid | input | 1 | A conversion word is present this cycle |
| conv_word | input | 16 | Conversion word: sample in bits 15:4, channel tag in bits 3:0 |
| bus_addr | input | 3 | Host register address |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, valid in the cycle bus_rd is high |
| irq | output | 1 | Half-full interrupt request |

## Verification
The assertions assume that the host never raises bus_rd and bus_wr in the same cycle, and that each strobe lasts one cycle per access. Under those conditions a high-byte read is the only thing that can lower the fill level outside a flush. The stimulus performs at most one bus access per clock, driven away from the active edge. Conversion words arrive as single-cycle pulses that may coincide with any bus access, which exercises the full-plus-removal case and the flush-plus-arrival case.

// File: rtl/tagfifo_pkg.sv
package tagfifo_pkg;
  localparam int ADR_CTRL = 0;
  localparam int ADR_ACK  = 1;
  localparam int ADR_STAT = 2;
  localparam int ADR_DLO  = 3;
  localparam int ADR_DHI  = 4;
  localparam int STAT_EMPTY = 0;
  localparam int STAT_HALF  = 1;
  localparam int STAT_OVF   = 2;
endpackage

// File: rtl/tagfifo_store.sv
module tagfifo_store #(
  parameter int DEPTH  = 1024,
  parameter int WORD_W = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic              flush,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] head,
  output logic [CW-1:0]     count,
  output logic              ovf
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          full, do_pop, do_push;

  assign full    = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop && (cnt_q != '0) && !flush;
  assign do_push = push && !flush && (!full || do_pop);

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
      ovf_d = 1'b0;
    end else begin
      if (do_push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
      if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
      if (push && full && !do_pop) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  assign head  = mem[rp_q];
  assign count = cnt_q;
  assign ovf   = ovf_q;
endmodule

// File: rtl/tagfifo_irq.sv
module tagfifo_irq #(
  parameter int CW   = 11,
  parameter int HALF = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          ack,
  output logic          half,
  output logic          irq
);
  logic hprev_q, irq_q, irq_d;

  assign half = (count >= CW'(HALF));

  always_comb begin
    irq_d = irq_q;
    if (half && !hprev_q) irq_d = 1'b1;
    else if (ack)         irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hprev_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      hprev_q <= half;
      irq_q   <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/tagfifo_regs.sv
module tagfifo_regs
  import tagfifo_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int BYTE_W = 8,
  parameter int CW     = 11,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] head,
  input  logic [CW-1:0]     count,
  input  logic              half,
  input  logic              ovf,
  output logic              en,
  output logic              ack,
  output logic              flush,
  output logic              pop,
  output logic [BYTE_W-1:0] bus_rdata
);
  logic [BYTE_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_we;

  assign ctrl_we = bus_wr && (bus_addr == ADDR_W'(ADR_CTRL));
  assign ack     = bus_wr && (bus_addr == ADDR_W'(ADR_ACK));
  assign flush   = bus_wr && (bus_addr == ADDR_W'(ADR_STAT));
  assign pop     = bus_rd && (bus_addr == ADDR_W'(ADR_DHI));

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) ctrl_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign en = ctrl_q[0];

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == ADDR_W'(ADR_CTRL)) bus_rdata = ctrl_q;
      else if (bus_addr == ADDR_W'(ADR_STAT)) begin
        bus_rdata[STAT_EMPTY] = (count == '0);
        bus_rdata[STAT_HALF]  = half;
        bus_rdata[STAT_OVF]   = ovf;
      end
      else if (bus_addr == ADDR_W'(ADR_DLO)) bus_rdata = head[BYTE_W-1:0];
      else if (bus_addr == ADDR_W'(ADR_DHI)) bus_rdata = head[WORD_W-1:BYTE_W];
    end
  end
endmodule

// File: rtl/tagfifo_top.sv
module tagfifo_top #(
  parameter int DEPTH  = 1024,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int CW     = $clog2(DEPTH) + 1,
  localparam int HALF   = DEPTH / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_valid,
  input  logic [WORD_W-1:0] conv_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq
);
  logic              en, ack_p, flush_p, pop_p, half, ovf;
  logic [WORD_W-1:0] head;
  logic [CW-1:0]     fill;

  tagfifo_regs #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .head(head), .count(fill),
    .half(half), .ovf(ovf), .en(en), .ack(ack_p), .flush(flush_p),
    .pop(pop_p), .bus_rdata(bus_rdata)
  );

  tagfifo_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .push(conv_valid && en), .pop(pop_p),
    .flush(flush_p), .din(conv_word), .head(head), .count(fill), .ovf(ovf)
  );

  tagfifo_irq #(.CW(CW), .HALF(HALF)) u_irq (
    .clk(clk), .rst_n(rst_n), .count(fill), .ack(ack_p),
    .half(half), .irq(irq)
  );
endmodule

// File: rtl/tagfifo_chk.sv
module tagfifo_chk #(
  parameter int DEPTH = 1024,
  localparam int CW   = $clog2(DEPTH) + 1,
  localparam int HALF = DEPTH / 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] fill,
  input logic          ovf,
  input logic          en,
  input logic          flush_p,
  input logic          ack_p,
  input logic          irq,
  input logic          conv_valid,
  input logic          bus_rd,
  input logic [2:0]    bus_addr
);
  p_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));
  p_no_push_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !flush_p) |=> fill <= $past(fill));
  p_low_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd3 && !conv_valid) |=> $stable(fill));
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !flush_p) |=> ovf);
  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_p |=> (fill == '0) && !ovf);
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack_p) |=> irq);
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(fill) >= CW'(HALF));
endmodule

bind tagfifo_top tagfifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fill(fill), .ovf(ovf), .en(en),
  .flush_p(flush_p), .ack_p(ack_p), .irq(irq), .conv_valid(conv_valid),
  .bus_rd(bus_rd), .bus_addr(bus_addr)
);

// File: tb/tagfifo_top_bench.sv
module tagfifo_top_bench;
  localparam int DEPTH = 1024;
  localparam int HALF  = 512;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, conv_valid, bus_wr, bus_rd;
  logic [15:0] conv_word;
  logic [2:0]  bus_addr;
  logic [7:0]  bus_wdata;
  wire  [7:0]  bus_rdata;
  wire         irq;

  tagfifo_top u_tagfifo_top (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_word(conv_word),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  logic [15:0] mq[$];
  logic [7:0]  m_ctrl;
  logic        m_ovf, m_irq, m_hprev;
  logic [7:0]  last;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] wd(input int i);
    return {12'(i * 7 + 3), 4'(i)};
  endfunction

  task automatic cyc(input logic [2:0] a, input logic rd, input logic wr,
                     input logic [7:0] d, input logic pv, input logic [15:0] pw);
    int  sz;
    bit  popok, hnow;
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = d;
    conv_valid = pv; conv_word = pw;
    #1;
    last = bus_rdata;
    check("R8 irq level", int'(irq), int'(m_irq));
    sz = mq.size();
    if (rd) begin
      case (a)
        3'd0: check("R4 control readback", last, m_ctrl);
        3'd2: check("R2 status", last, {m_ovf, sz >= HALF, sz == 0});
        3'd3: if (sz > 0) check("R3 low byte", last, mq[0][7:0]);
        3'd4: if (sz > 0) check("R3 high byte", last, mq[0][15:8]);
        default: check("R2 unused address reads zero", last, 0);
      endcase
    end
    @(posedge clk);
    #1;
    hnow  = (sz >= HALF);
    popok = rd && a == 3'd4 && sz > 0;
    if (wr && a == 3'd2) begin
      mq.delete();
      m_ovf = 1'b0;
    end else begin
      if (popok) void'(mq.pop_front());
      if (pv && m_ctrl[0]) begin
        if (sz == DEPTH && !popok) m_ovf = 1'b1;
        else mq.push_back(pw);
      end
    end
    if (wr && a == 3'd0) m_ctrl = d;
    if (hnow && !m_hprev) m_irq = 1'b1;
    else if (wr && a == 3'd1) m_irq = 1'b0;
    m_hprev = hnow;
  endtask

  task automatic idle();                     cyc(0, 0, 0, 0, 0, 0); endtask
  task automatic push(input logic [15:0] w); cyc(0, 0, 0, 0, 1, w); endtask
  task automatic rdreg(input logic [2:0] a); cyc(a, 1, 0, 0, 0, 0); endtask
  task automatic wrreg(input logic [2:0] a, input logic [7:0] d);
    cyc(a, 0, 1, d, 0, 0);
  endtask
  task automatic popword(output logic [15:0] w);
    rdreg(3); w[7:0] = last;
    rdreg(4); w[15:8] = last;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] w;
    rst_n = 1'b0; conv_valid = 0; conv_word = 0; bus_addr = 0;
    bus_wr = 0; bus_rd = 0; bus_wdata = 0;
    m_ctrl = 0; m_ovf = 0; m_irq = 0; m_hprev = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    rdreg(2); check("R9 reset status empty", last, 8'h01);
    rdreg(0); check("R9 reset control", last, 0);
    check("R9 reset irq", int'(irq), 0);

    push(16'h1234); idle();
    rdreg(2); check("R4 disabled word dropped", last, 8'h01);

    wrreg(0, 8'h01);
    rdreg(0); check("R4 enable readback", last, 8'h01);
    for (int i = 0; i < 3; i++) push(wd(i));
    rdreg(3); rdreg(3); check("R5 low read twice keeps head", last, wd(0) & 16'hff);
    rdreg(2); check("R5 low reads remove nothing", last, 8'h00);
    for (int i = 0; i < 3; i++) begin
      popword(w); check("R1 R3 arrival order", w, wd(i));
    end
    rdreg(4); rdreg(2); check("R5 pop on empty harmless", last, 8'h01);

    for (int i = 0; i < HALF; i++) push(wd(i + 10));
    idle();
    check("R8 irq after half crossing", int'(irq), 1);
    rdreg(2); check("R2 half flag", last, 8'h02);
    wrreg(1, 8'h00);
    check("R8 irq acknowledged", int'(irq), 0);
    for (int i = 0; i < HALF; i++) begin
      popword(w); check("R1 burst drain", w, wd(i + 10));
    end
    rdreg(2); check("R1 drained after burst", last, 8'h01);

    for (int i = 0; i < DEPTH; i++) push(wd(i + 2000));
    rdreg(2); check("R1 full without overflow", last, 8'h02);
    push(16'hdead); push(16'hbeef);
    rdreg(2); check("R6 overflow set", last, 8'h06);
    rdreg(3);
    cyc(4, 1, 0, 0, 1, 16'h5a5a);
    rdreg(2); check("R6 overflow sticky after pop", last, 8'h06);
    popword(w); check("R6 dropped words absent", w, wd(2001));
    check("R7 irq set before flush", int'(irq), 1);
    cyc(2, 0, 1, 0, 1, 16'h7777);
    rdreg(2); check("R7 flush empties and clears", last, 8'h01);
    check("R7 flush leaves irq", int'(irq), 1);
    rdreg(0); check("R7 flush leaves control", last, 8'h01);
    wrreg(1, 8'h00);

    for (int i = 0; i < HALF; i++) push(wd(i));
    wrreg(1, 8'h00);
    check("R8 crossing wins over ack", int'(irq), 1);
    wrreg(1, 8'h00);
    check("R8 later ack clears", int'(irq), 0);

    wrreg(0, 8'h00);
    wrreg(2, 8'h00);
    push(16'h0101); idle();
    rdreg(2); check("R4 disabled after shutdown", last, 8'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule